// File: doc/BRIEF.md
# Fractional Reference Clock Divider

This block produces a programmable reference clock from one of several source clocks. All logic runs on a single fast system clock. Each source arrives as a one-cycle tick enable, so "source cycle" below means one tick. The output runs at the source rate divided by 2 × (div + trim/512). Here div is an integer and trim is a 9-bit fraction. A fractional accumulator stretches some half-periods by one tick, and this sets the average rate.

Software programs the block through a 32-bit register port. It has a control word and a trim word, and each has plain, clear-alias and set-alias write addresses. New divider, trim and source settings are held in a staging copy. The running divider takes them only after software sets the switch bit. The block clears the switch bit at the exact cycle the new ratio takes over. This happens at a rising output boundary, or at once when the divider is stopped.

The expected sequence has six steps. Drop run and output enable. Wait for the busy flag and the switch bit to read 0. Write the new settings. Raise run and output enable. Set the switch bit. Poll until the switch bit clears.

Top module: `refclk_frac_div`

## Requirements
- R1: After reset both the control word (address 0x00) and the trim word (address 0x10) read 0, and `ref_out` is low.
- R2: With trim 0 and a nonzero div, each output half-period (high, then low) lasts exactly div ticks of the selected source. The divided output starts high one cycle after the divider starts.
- R3: At the end of every half-period, trim is added to a 9-bit accumulator. When the sum carries out, the next half-period lasts one extra tick. Over time the period averages 2 × (div + trim/512) ticks.
- R4: With div 0, `ref_out` follows the selected source tick directly (gated only by output enable and busy), and trim has no effect.
- R5: Source select code 0 takes `tick_sys`, code 7 takes `tick_pll` and code 8 takes `tick_ext`. Every other code supplies no ticks, so the output freezes.
- R6: The select, div and trim fields written by software are staged. Setting the switch bit (control bit 9) through a plain write or the set alias requests a transfer. The hardware clears that bit in the cycle the staged values reach the divider. This happens at a rising output boundary while running, or on the next clock while stopped. Until then the output keeps the old ratio. Software cannot clear the bit.
- R7: Control word layout: select in bits [3:0], busy in bit 8 (read-only), switch in bit 9, output enable in bit 12, run in bit 15, and div in bits [30:16]. The trim word holds trim in bits [31:23]. All other bits read 0. Reads return the staged values.
- R8: A write to 0x04 or 0x14 clears the control or trim bits that are 1 in the data. A write to 0x08 or 0x18 sets them. Bits that are 0 in the data keep their value.
- R9: The busy flag rises one clock after run is seen high. After run is cleared, a running divider finishes its current period, and busy falls at the boundary where the output would next rise. In div-0 mode busy falls on the next clock.
- R10: While output enable is 0, `ref_out` stays low, but the divider keeps running and busy stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write byte address (0x00/04/08 control, 0x10/14/18 trim) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read byte address (0x00 control, 0x10 trim) |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| tick_sys | input | 1 | System clock source tick |
| tick_pll | input | 1 | PLL source tick |
| tick_ext | input | 1 | External reference source tick |
| ref_out | output | 1 | Divided reference clock |

## Verification
Register writes show up in read data at the first sample after the write edge. Busy rises one clock later, and the bench checks busy at both of those samples. The divided output changes one clock after the source tick that ends a half-period. In div-0 mode it changes in the same cycle as the tick, so the reference model applies every clock edge with the inputs that were stable at that edge. It then compares output and read data in the middle of the following low phase. Switch completion depends on the next rising boundary and has no fixed delay. The bench polls for it with a bound, and then counts output rising edges over windows sized to the expected period, with an allowance of one edge.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
   localparam int REG_W   = 32;
   localparam int ADDR_W  = 5;
   localparam int SEL_W   = 4;
   localparam int TRIM_FW = 9;

   // bit positions in the control and trim words
   localparam int POS_SEL  = 0;
   localparam int POS_BUSY = 8;
   localparam int POS_SW   = 9;
   localparam int POS_OE   = 12;
   localparam int POS_RUN  = 15;
   localparam int POS_DIV  = 16;
   localparam int POS_TRIM = 23;

   localparam logic [ADDR_W-1:0] A_CTL      = 5'h00;
   localparam logic [ADDR_W-1:0] A_CTL_CLR  = 5'h04;
   localparam logic [ADDR_W-1:0] A_CTL_SET  = 5'h08;
   localparam logic [ADDR_W-1:0] A_TRIM     = 5'h10;
   localparam logic [ADDR_W-1:0] A_TRIM_CLR = 5'h14;
   localparam logic [ADDR_W-1:0] A_TRIM_SET = 5'h18;

   localparam logic [SEL_W-1:0] SRC_SYS = 4'd0;
   localparam logic [SEL_W-1:0] SRC_PLL = 4'd7;
   localparam logic [SEL_W-1:0] SRC_EXT = 4'd8;

   typedef enum logic [1:0] {WK_PLAIN, WK_CLEAR, WK_SET, WK_NONE} wr_kind_e;

   function automatic logic [REG_W-1:0] merge_word(input logic [REG_W-1:0] old_w,
                                                   input logic [REG_W-1:0] data,
                                                   input wr_kind_e kind);
      case (kind)
         WK_PLAIN: merge_word = data;
         WK_CLEAR: merge_word = old_w & ~data;
         WK_SET:   merge_word = old_w | data;
         default:  merge_word = old_w;
      endcase
   endfunction
endpackage

// File: rtl/refclk_regs.sv
module refclk_regs
   import refclk_pkg::*;
#(
   parameter int DIV_W  = 15,
   parameter int TRIM_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data,
   input  logic              busy,
   input  logic              sw_done,
   output logic [SEL_W-1:0]  stg_sel,
   output logic [DIV_W-1:0]  stg_div,
   output logic [TRIM_W-1:0] stg_trim,
   output logic              oe,
   output logic              run,
   output logic              sw_pend
);
   wr_kind_e ctl_kind, trim_kind;
   logic [REG_W-1:0] ctl_word, trim_word, ctl_next, trim_next;

   always_comb begin
      ctl_kind  = WK_NONE;
      trim_kind = WK_NONE;
      if (wr_en) begin
         case (wr_addr)
            A_CTL:      ctl_kind  = WK_PLAIN;
            A_CTL_CLR:  ctl_kind  = WK_CLEAR;
            A_CTL_SET:  ctl_kind  = WK_SET;
            A_TRIM:     trim_kind = WK_PLAIN;
            A_TRIM_CLR: trim_kind = WK_CLEAR;
            A_TRIM_SET: trim_kind = WK_SET;
            default: ;
         endcase
      end
   end

   always_comb begin
      ctl_word = '0;
      ctl_word[POS_SEL +: SEL_W] = stg_sel;
      ctl_word[POS_BUSY]         = busy;
      ctl_word[POS_SW]           = sw_pend;
      ctl_word[POS_OE]           = oe;
      ctl_word[POS_RUN]          = run;
      ctl_word[POS_DIV +: DIV_W] = stg_div;
      trim_word = '0;
      trim_word[POS_TRIM +: TRIM_W] = stg_trim;
   end

   assign ctl_next  = merge_word(ctl_word, wr_data, ctl_kind);
   assign trim_next = merge_word(trim_word, wr_data, trim_kind);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg_sel  <= '0;
         stg_div  <= '0;
         stg_trim <= '0;
         oe       <= 1'b0;
         run      <= 1'b0;
         sw_pend  <= 1'b0;
      end else begin
         if (sw_done) sw_pend <= 1'b0;
         if (ctl_kind != WK_NONE) begin
            stg_sel <= ctl_next[POS_SEL +: SEL_W];
            stg_div <= ctl_next[POS_DIV +: DIV_W];
            oe      <= ctl_next[POS_OE];
            run     <= ctl_next[POS_RUN];
            if (ctl_kind != WK_CLEAR && wr_data[POS_SW]) sw_pend <= 1'b1;
         end
         if (trim_kind != WK_NONE) stg_trim <= trim_next[POS_TRIM +: TRIM_W];
      end
   end

   always_comb begin
      case (rd_addr)
         A_CTL:   rd_data = ctl_word;
         A_TRIM:  rd_data = trim_word;
         default: rd_data = '0;
      endcase
   end

   // R6
   sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw_pend) |-> $past(sw_done))
      else $error("switch bit cleared without a transfer");
endmodule

// File: rtl/refclk_src_sel.sv
module refclk_src_sel
   import refclk_pkg::*;
#(
   parameter bit HAS_EXT = 1'b1
) (
   input  logic [SEL_W-1:0] sel,
   input  logic             tick_sys,
   input  logic             tick_pll,
   input  logic             tick_ext,
   output logic             tick
);
   generate
      if (HAS_EXT) begin : g_with_ext
         always_comb begin
            case (sel)
               SRC_SYS: tick = tick_sys;
               SRC_PLL: tick = tick_pll;
               SRC_EXT: tick = tick_ext;
               default: tick = 1'b0;
            endcase
         end
      end else begin : g_no_ext
         logic ext_unused;
         assign ext_unused = tick_ext;
         always_comb begin
            case (sel)
               SRC_SYS: tick = tick_sys;
               SRC_PLL: tick = tick_pll;
               default: tick = ext_unused & 1'b0;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/refclk_core.sv
module refclk_core
   import refclk_pkg::*;
#(
   parameter int DIV_W  = 15,
   parameter int TRIM_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              sw_pend,
   input  logic [SEL_W-1:0]  stg_sel,
   input  logic [DIV_W-1:0]  stg_div,
   input  logic [TRIM_W-1:0] stg_trim,
   input  logic              tick,
   output logic [SEL_W-1:0]  run_sel,
   output logic              busy,
   output logic              level,
   output logic              bypass,
   output logic              sw_done
);
   localparam int HL_W = DIV_W + 1;

   logic [DIV_W-1:0]  run_div;
   logic [TRIM_W-1:0] run_trim;
   logic [DIV_W-1:0]  cnt;
   logic [TRIM_W-1:0] acc;
   logic              ext;
   logic [HL_W-1:0]   half_len;
   logic [TRIM_W:0]   acc_sum;
   logic              half_end, rise_evt;

   assign bypass   = (run_div == '0);
   assign half_len = {1'b0, run_div} + HL_W'(ext);
   assign half_end = tick && ((HL_W'(cnt) + HL_W'(1)) == half_len);
   assign acc_sum  = {1'b0, acc} + {1'b0, run_trim};
   assign rise_evt = busy && (bypass ? tick : (half_end && !level));
   assign sw_done  = sw_pend && (!busy || (rise_evt && run));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_sel  <= '0;
         run_div  <= '0;
         run_trim <= '0;
         busy     <= 1'b0;
         level    <= 1'b0;
         cnt      <= '0;
         acc      <= '0;
         ext      <= 1'b0;
      end else begin
         if (sw_done) begin
            run_sel  <= stg_sel;
            run_div  <= stg_div;
            run_trim <= stg_trim;
         end
         if (!busy) begin
            if (run) begin
               busy  <= 1'b1;
               level <= 1'b1;
               cnt   <= '0;
               acc   <= '0;
               ext   <= 1'b0;
            end
         end else if (bypass) begin
            if (!run) begin
               busy  <= 1'b0;
               level <= 1'b0;
            end
         end else if (tick) begin
            if (half_end) begin
               cnt <= '0;
               acc <= acc_sum[TRIM_W-1:0];
               ext <= acc_sum[TRIM_W];
               if (level) begin
                  level <= 1'b0;
               end else if (!run) begin
                  busy <= 1'b0;
                  acc  <= '0;
                  ext  <= 1'b0;
               end else begin
                  level <= 1'b1;
               end
            end else begin
               cnt <= cnt + DIV_W'(1);
            end
         end
      end
   end

   // R9
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(run))
      else $error("busy rose without run");

   // R9
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(!run))
      else $error("busy fell while run was high");

   // R6
   staged_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(run_div) || !$stable(run_trim)) |-> $past(sw_done))
      else $error("running ratio changed without a switch");

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !bypass) |-> (HL_W'(cnt) < half_len))
      else $error("half-period counter past its limit");
endmodule

// File: rtl/refclk_frac_div.sv
module refclk_frac_div
   import refclk_pkg::*;
#(
   parameter int DIV_W   = 15,
   parameter int TRIM_W  = 9,
   parameter bit HAS_EXT = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [4:0]  wr_addr,
   input  logic [31:0] wr_data,
   input  logic [4:0]  rd_addr,
   output logic [31:0] rd_data,
   input  logic        tick_sys,
   input  logic        tick_pll,
   input  logic        tick_ext,
   output logic        ref_out
);
   generate
      if (DIV_W < 1 || DIV_W > 15) begin : g_bad_div
         $error("DIV_W must be within 1..15");
      end
      if (TRIM_W < 1 || TRIM_W > TRIM_FW) begin : g_bad_trim
         $error("TRIM_W must be within 1..9");
      end
   endgenerate

   logic [SEL_W-1:0]  stg_sel, run_sel;
   logic [DIV_W-1:0]  stg_div;
   logic [TRIM_W-1:0] stg_trim;
   logic oe, run, sw_pend, sw_done, busy, level, bypass, tick;

   refclk_regs #(.DIV_W(DIV_W), .TRIM_W(TRIM_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .busy(busy), .sw_done(sw_done), .stg_sel(stg_sel), .stg_div(stg_div),
      .stg_trim(stg_trim), .oe(oe), .run(run), .sw_pend(sw_pend)
   );

   refclk_src_sel #(.HAS_EXT(HAS_EXT)) u_src (
      .sel(run_sel), .tick_sys(tick_sys), .tick_pll(tick_pll),
      .tick_ext(tick_ext), .tick(tick)
   );

   refclk_core #(.DIV_W(DIV_W), .TRIM_W(TRIM_W)) u_core (
      .clk(clk), .rst_n(rst_n), .run(run), .sw_pend(sw_pend),
      .stg_sel(stg_sel), .stg_div(stg_div), .stg_trim(stg_trim),
      .tick(tick), .run_sel(run_sel), .busy(busy), .level(level),
      .bypass(bypass), .sw_done(sw_done)
   );

   assign ref_out = oe && busy && (bypass ? tick : level);

   // R10
   oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe && $past(busy) && run) |-> busy)
      else $error("divider stopped while only output enable was low");
endmodule

// File: tb/refclk_frac_div_test.sv
module refclk_frac_div_test;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n, wr_en, tick_sys, tick_pll, tick_ext, ref_out;
   logic [4:0]  wr_addr, rd_addr;
   logic [31:0] wr_data, rd_data;
   int total = 0, bad = 0, cyc = 0;

   refclk_frac_div uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .tick_sys(tick_sys), .tick_pll(tick_pll), .tick_ext(tick_ext),
      .ref_out(ref_out)
   );

   // source tick patterns: every cycle, every 2nd, every 3rd
   always @(posedge clk) begin
      #1;
      cyc++;
      tick_sys = 1'b1;
      tick_pll = (cyc % 2 == 0);
      tick_ext = (cyc % 3 == 0);
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------- behavioural reference model ----------
   int m_sel, m_div, m_trim, r_sel, r_div, r_trim, seen, frac;
   bit m_oe, m_on, m_sw, m_act, lvl, extra;

   function automatic bit src_of(input int s);
      if (s == 0) return tick_sys;
      if (s == 7) return tick_pll;
      if (s == 8) return tick_ext;
      return 1'b0;
   endfunction

   function automatic logic [31:0] exp_rd(input logic [4:0] a);
      logic [31:0] w = 32'h0;
      if (a == 5'h00) begin
         w[3:0] = m_sel[3:0]; w[8] = m_act; w[9] = m_sw;
         w[12] = m_oe; w[15] = m_on; w[30:16] = m_div[14:0];
      end else if (a == 5'h10) begin
         w[31:23] = m_trim[8:0];
      end
      return w;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sel = 0; m_div = 0; m_trim = 0; r_sel = 0; r_div = 0; r_trim = 0;
         seen = 0; frac = 0; m_oe = 0; m_on = 0; m_sw = 0; m_act = 0;
         lvl = 0; extra = 0;
      end else begin
         bit t, take;
         t = src_of(r_sel);
         take = 0;
         if (!m_act) begin
            take = m_sw;
            if (m_on) begin m_act = 1; lvl = 1; seen = 0; frac = 0; extra = 0; end
         end else if (r_div == 0) begin
            if (!m_on) begin m_act = 0; lvl = 0; end
            else if (t) take = m_sw;
         end else if (t) begin
            seen++;
            if (seen == r_div + extra) begin
               seen = 0;
               frac = frac + r_trim;
               extra = (frac >= 512);
               frac = frac % 512;
               if (lvl) lvl = 0;
               else if (!m_on) begin m_act = 0; frac = 0; extra = 0; end
               else begin lvl = 1; take = m_sw; end
            end
         end
         if (take) begin r_sel = m_sel; r_div = m_div; r_trim = m_trim; m_sw = 0; end
         if (wr_en) begin
            case (wr_addr)
               5'h00: begin m_sel = wr_data[3:0]; m_oe = wr_data[12]; m_on = wr_data[15];
                            m_div = wr_data[30:16]; if (wr_data[9]) m_sw = 1; end
               5'h04: begin m_sel = m_sel & ~int'(wr_data[3:0]); m_oe = m_oe & ~wr_data[12];
                            m_on = m_on & ~wr_data[15]; m_div = m_div & ~int'(wr_data[30:16]); end
               5'h08: begin m_sel = m_sel | int'(wr_data[3:0]); m_oe = m_oe | wr_data[12];
                            m_on = m_on | wr_data[15]; m_div = m_div | int'(wr_data[30:16]);
                            if (wr_data[9]) m_sw = 1; end
               5'h10: m_trim = wr_data[31:23];
               5'h14: m_trim = m_trim & ~int'(wr_data[31:23]);
               5'h18: m_trim = m_trim | int'(wr_data[31:23]);
               default: ;
            endcase
         end
      end
   end

   // every-clock comparison, midway through the low phase
   always @(negedge clk) begin
      if (rst_n) begin
         bit eo;
         logic [31:0] er;
         eo = m_oe && m_act && ((r_div == 0) ? src_of(r_sel) : lvl);
         er = exp_rd(rd_addr);
         chk(ref_out == eo, "R2 model output", {31'b0, ref_out}, {31'b0, eo});
         chk(rd_data == er, "R7 model readback", rd_data, er);
      end
   end

   // ---------- stimulus helpers ----------
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic set_rd(input logic [4:0] a);
      @(posedge clk); #1;
      rd_addr = a;
   endtask

   task automatic wait_sw_clear();
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         if (rd_data[9] == 1'b0) break;
      end
      chk(rd_data[9] == 1'b0, "R6 switch completes", {31'b0, rd_data[9]}, 32'h0);
   endtask

   task automatic prog(input int sel, input int dv, input int tr);
      wr(5'h04, 32'h0000_9000);
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         if (rd_data[9:8] == 2'b00) break;
      end
      chk(rd_data[9:8] == 2'b00, "R9 stopped before reprogram", {30'b0, rd_data[9:8]}, 32'h0);
      wr(5'h00, (32'(dv) << 16) | 32'(sel));
      wr(5'h10, 32'(tr) << 23);
      wr(5'h08, 32'h0000_9000);
      wr(5'h08, 32'h0000_0200);
      wait_sw_clear();
   endtask

   task automatic edges(input int n, output int e);
      bit prev;
      e = 0;
      @(negedge clk); prev = ref_out;
      repeat (n) begin
         @(negedge clk);
         if (ref_out && !prev) e++;
         prev = ref_out;
      end
   endtask

   task automatic near(input int act, input int exp, input string req);
      chk((act >= exp - 1) && (act <= exp + 1), req, 32'(act), 32'(exp));
   endtask

   task automatic hi_width(output int w);
      int k;
      w = 0;
      k = 0;
      do begin @(negedge clk); k++; end while (ref_out && k < 100);
      do begin @(negedge clk); k++; end while (!ref_out && k < 200);
      while (ref_out && w < 100) begin w++; @(negedge clk); end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL all: watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int e, w;
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
      tick_sys = 1'b0; tick_pll = 1'b0; tick_ext = 1'b0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      @(negedge clk);
      chk(rd_data == 32'h0, "R1 control after reset", rd_data, 32'h0);
      chk(ref_out == 1'b0, "R1 output after reset", {31'b0, ref_out}, 32'h0);
      set_rd(5'h10);
      @(negedge clk);
      chk(rd_data == 32'h0, "R1 trim after reset", rd_data, 32'h0);
      set_rd(5'h00);

      // R2 integer divide on sys ticks: period 6
      prog(0, 3, 0);
      edges(600, e); near(e, 100, "R2 div3 edge count");
      hi_width(w); chk(w == 3, "R2 high half width", 32'(w), 32'd3);

      // R6 staging: new div written, old rate kept until switch
      wr(5'h00, (32'd5 << 16) | 32'h0000_9000);
      edges(600, e); near(e, 100, "R6 staged div not applied");
      wr(5'h08, 32'h0000_0200);
      wait_sw_clear();
      edges(600, e); near(e, 60, "R6 div5 after switch");

      // R3 fractional trim
      wr(5'h10, 32'd256 << 23);
      wr(5'h08, 32'h0000_0200);
      wait_sw_clear();
      edges(1100, e); near(e, 100, "R3 div5 trim256");
      prog(0, 1, 511);
      edges(3996, e); near(e, 1000, "R3 div1 trim511");

      // R4 bypass on pll ticks, trim ignored
      prog(7, 0, 300);
      edges(600, e); near(e, 300, "R4 bypass edge count");
      hi_width(w); chk(w == 1, "R4 bypass pulse width", 32'(w), 32'd1);

      // R5 source codes
      prog(8, 1, 0);
      edges(600, e); near(e, 100, "R5 ext source div1");
      prog(7, 2, 0);
      edges(800, e); near(e, 100, "R5 pll source div2");

      // R10 output enable gating
      prog(0, 3, 0);
      wr(5'h04, 32'h0000_1000);
      edges(300, e); chk(e == 0, "R10 output held low", 32'(e), 32'd0);
      @(negedge clk);
      chk(rd_data[8] == 1'b1, "R10 divider still busy", {31'b0, rd_data[8]}, 32'h1);
      wr(5'h08, 32'h0000_1000);
      edges(600, e); near(e, 100, "R10 output restored");

      // R9 busy after run is cleared, and restart timing
      wr(5'h04, 32'h0000_8000);
      w = 0;
      while (w < 20) begin @(negedge clk); if (!rd_data[8]) break; w++; end
      chk(w <= 7, "R9 busy falls within one period", 32'(w), 32'd7);
      edges(100, e); chk(e == 0, "R9 quiet after stop", 32'(e), 32'd0);
      wr(5'h08, 32'h0000_8000);
      @(negedge clk);
      chk(rd_data[8] == 1'b0, "R9 busy not yet set", {31'b0, rd_data[8]}, 32'h0);
      @(negedge clk);
      chk(rd_data[8] == 1'b1, "R9 busy one clock later", {31'b0, rd_data[8]}, 32'h1);

      // R8 set and clear aliases
      wr(5'h10, 32'h0A0 << 23);
      wr(5'h18, 32'h005 << 23);
      set_rd(5'h10);
      @(negedge clk);
      chk(rd_data == (32'h0A5 << 23), "R8 trim set alias", rd_data, 32'h0A5 << 23);
      wr(5'h14, 32'h020 << 23);
      @(negedge clk);
      chk(rd_data == (32'h085 << 23), "R8 trim clear alias", rd_data, 32'h085 << 23);
      set_rd(5'h00);
      wr(5'h08, 32'h0000_0003);
      @(negedge clk);
      chk(rd_data[3:0] == 4'h3, "R8 control set alias", {28'b0, rd_data[3:0]}, 32'h3);
      chk(rd_data[15] == 1'b1, "R8 other bits kept", {31'b0, rd_data[15]}, 32'h1);
      wr(5'h04, 32'h0000_0003);
      @(negedge clk);
      chk(rd_data[3:0] == 4'h0, "R8 control clear alias", {28'b0, rd_data[3:0]}, 32'h0);

      // R5 unused code freezes the output
      prog(3, 2, 0);
      edges(200, e); chk(e == 0, "R5 unused code no edges", 32'(e), 32'd0);

      // R1 reset again
      @(posedge clk); #1 rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(rd_data == 32'h0, "R1 control after second reset", rd_data, 32'h0);
      chk(ref_out == 1'b0, "R1 output after second reset", {31'b0, ref_out}, 32'h0);
      repeat (5) @(negedge clk);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule